// File: doc/BRIEF.md
# Display Window Fetch Address Generator

This block turns a display window description into the stream of 32-bit word addresses a scanout engine reads from video memory. The timing generator gives it strobes: a field start with a flag naming the field, a line start, and a window-active qualifier. The block answers each active cycle of a started line with one read request and one word address, until the window line has been fully fetched.

Two field base addresses are supplied: one for the long field and one for the short field. A packed size word carries the width and height of the window, both stored minus one, and a modulo. With a modulo of one, consecutive lines are contiguous, which is the progressive case. For interlaced output the modulo is one line length plus one, so each field takes every other line of the image. The short field's base is then one line length above the long field's base. The base and the geometry are captured at each field start, so software can pan the image during a field without tearing it.

Top module: `dwin_fetch_addr`

## Requirements
- R1: After reset `rd_req_o` is 0 and `rd_addr_o` is 0. Until the first field start, no request is issued, whatever the line-start and window-active inputs do.
- R2: The size word is decoded with the width in words minus one in bits 9:0, the height in lines minus one in bits 19:10, and the modulo in bits 29:20.
- R3: At a field start, the field's base is taken from `base_long_i` when `field_sel_i` is 0 and from `base_short_i` when it is 1. The first line of the field starts at that base.
- R4: After an accepted line start, each cycle with `win_active_i` high yields one request in the following cycle. The words are consecutive, beginning at the line's start address. A line carries exactly width+1 requests. Cycles with `win_active_i` low pause the line and skip no word.
- R5: Each line after the first starts at the previous line's start plus width plus modulo words. With modulo equal to the line length plus one, alternate image lines are skipped (interlaced).
- R6: After height+1 lines in a field, line starts are ignored and no request is issued until the next field start.
- R7: Changes to the base inputs or to the size word during a field do not alter that field's addresses. They take effect from the next field start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| field_start_i | input | 1 | One-cycle strobe at the start of a field |
| field_sel_i | input | 1 | Field being started: 0 long, 1 short |
| line_start_i | input | 1 | One-cycle strobe at the start of a line |
| win_active_i | input | 1 | Window-active qualifier, one word per high cycle |
| base_long_i | input | ADDR_W | Long field base word address |
| base_short_i | input | ADDR_W | Short field base word address |
| size_i | input | 30 | Packed modulo, height-1 and width-1 |
| rd_req_o | output | 1 | Read request, one per word |
| rd_addr_o | output | ADDR_W | Word address of the request |

## Verification
A field start or an accepted line start takes effect at the clock edge that samples it. The first request then follows one cycle after the first active cycle is sampled. Requests appear one cycle after each sampled active cycle. The bench drives its inputs just after a rising edge and samples at the falling edge. It lets two idle cycles pass after each line before it compares that line's request count. Every request address is checked against the base plus line number times the step plus the word index.

// File: rtl/dwin_pkg.sv
package dwin_pkg;
  localparam int FLD_W  = 10;
  localparam int SIZE_W = 3 * FLD_W;

  typedef struct packed {
    logic [FLD_W-1:0] modv;
    logic [FLD_W-1:0] hgt_m1;
    logic [FLD_W-1:0] wid_m1;
  } geom_t;
endpackage

// File: rtl/dwin_shadow.sv
module dwin_shadow
  import dwin_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start,
  input  logic              field_sel,
  input  logic [ADDR_W-1:0] base_long,
  input  logic [ADDR_W-1:0] base_short,
  input  logic [SIZE_W-1:0] size_raw,
  output logic [ADDR_W-1:0] base_q,
  output geom_t             geom_q
);
  logic [ADDR_W-1:0] base_d;
  geom_t             geom_d;

  always_comb begin
    base_d = base_q;
    geom_d = geom_q;
    if (field_start) begin
      base_d = field_sel ? base_short : base_long;
      geom_d = geom_t'(size_raw);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      geom_q <= '0;
    end else begin
      base_q <= base_d;
      geom_q <= geom_d;
    end
  end
endmodule

// File: rtl/dwin_line_seq.sv
module dwin_line_seq
  import dwin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_start,
  input  logic             line_start,
  input  logic             win_active,
  input  logic [FLD_W-1:0] wid_m1,
  input  logic [FLD_W-1:0] hgt_m1,
  output logic             in_field,
  output logic             line_go,
  output logic             fetch_en,
  output logic [FLD_W:0]   lines_done
);
  logic             busy_q, busy_d;
  logic             infld_q, infld_d;
  logic [FLD_W-1:0] wcnt_q, wcnt_d;
  logic [FLD_W:0]   lcnt_q, lcnt_d;
  logic             last_word;

  assign in_field   = infld_q;
  assign lines_done = lcnt_q;
  assign line_go    = infld_q & ~busy_q & line_start & ~field_start;
  assign fetch_en   = busy_q & win_active & ~field_start;
  assign last_word  = fetch_en & (wcnt_q == wid_m1);

  always_comb begin
    busy_d  = busy_q;
    infld_d = infld_q;
    wcnt_d  = wcnt_q;
    lcnt_d  = lcnt_q;
    if (field_start) begin
      busy_d  = 1'b0;
      infld_d = 1'b1;
      wcnt_d  = '0;
      lcnt_d  = '0;
    end else begin
      if (line_go) begin
        busy_d = 1'b1;
        wcnt_d = '0;
      end
      if (fetch_en) begin
        wcnt_d = wcnt_q + 1'b1;
        if (last_word) begin
          busy_d = 1'b0;
          lcnt_d = lcnt_q + 1'b1;
          if (lcnt_q == {1'b0, hgt_m1}) infld_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      infld_q <= 1'b0;
      wcnt_q  <= '0;
      lcnt_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      infld_q <= infld_d;
      wcnt_q  <= wcnt_d;
      lcnt_q  <= lcnt_d;
    end
  end
endmodule

// File: rtl/dwin_addr_gen.sv
module dwin_addr_gen
  import dwin_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start,
  input  logic              line_go,
  input  logic              fetch_en,
  input  logic [ADDR_W-1:0] base,
  input  logic [FLD_W-1:0]  wid_m1,
  input  logic [FLD_W-1:0]  modv,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int PAD_W = ADDR_W - FLD_W;

  logic              first_q, first_d;
  logic [ADDR_W-1:0] lbase_q, lbase_d;
  logic [ADDR_W-1:0] cur_q, cur_d;
  logic              req_d;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] step;

  assign step = {{PAD_W{1'b0}}, wid_m1} + {{PAD_W{1'b0}}, modv};

  always_comb begin
    first_d = first_q;
    lbase_d = lbase_q;
    cur_d   = cur_q;
    req_d   = 1'b0;
    addr_d  = rd_addr;
    if (field_start) begin
      first_d = 1'b1;
    end else if (line_go) begin
      first_d = 1'b0;
      lbase_d = first_q ? base : lbase_q + step;
      cur_d   = lbase_d;
    end else if (fetch_en) begin
      req_d  = 1'b1;
      addr_d = cur_q;
      cur_d  = cur_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      lbase_q <= '0;
      cur_q   <= '0;
      rd_req  <= 1'b0;
      rd_addr <= '0;
    end else begin
      first_q <= first_d;
      lbase_q <= lbase_d;
      cur_q   <= cur_d;
      rd_req  <= req_d;
      rd_addr <= addr_d;
    end
  end
endmodule

// File: rtl/dwin_fetch_addr.sv
module dwin_fetch_addr
  import dwin_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start_i,
  input  logic              field_sel_i,
  input  logic              line_start_i,
  input  logic              win_active_i,
  input  logic [ADDR_W-1:0] base_long_i,
  input  logic [ADDR_W-1:0] base_short_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  logic [1:0]        rst_pipe;
  logic              rst_ns;
  logic [ADDR_W-1:0] shd_base;
  geom_t             shd_geom;
  logic              in_field;
  logic              line_go;
  logic              fetch_en;
  logic [FLD_W:0]    lines_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  dwin_shadow #(.ADDR_W(ADDR_W)) u_shadow (
    .clk(clk), .rst_n(rst_ns),
    .field_start(field_start_i), .field_sel(field_sel_i),
    .base_long(base_long_i), .base_short(base_short_i),
    .size_raw(size_i), .base_q(shd_base), .geom_q(shd_geom)
  );

  dwin_line_seq u_seq (
    .clk(clk), .rst_n(rst_ns),
    .field_start(field_start_i), .line_start(line_start_i),
    .win_active(win_active_i),
    .wid_m1(shd_geom.wid_m1), .hgt_m1(shd_geom.hgt_m1),
    .in_field(in_field), .line_go(line_go), .fetch_en(fetch_en),
    .lines_done(lines_done)
  );

  dwin_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_ns),
    .field_start(field_start_i), .line_go(line_go), .fetch_en(fetch_en),
    .base(shd_base), .wid_m1(shd_geom.wid_m1), .modv(shd_geom.modv),
    .rd_req(rd_req_o), .rd_addr(rd_addr_o)
  );
endmodule

// File: rtl/dwin_fetch_chk.sv
module dwin_fetch_chk
  import dwin_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              field_start_i,
  input logic              field_sel_i,
  input logic [ADDR_W-1:0] base_long_i,
  input logic [ADDR_W-1:0] base_short_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              in_field,
  input logic [ADDR_W-1:0] shd_base,
  input geom_t             shd_geom,
  input logic [FLD_W:0]    lines_done
);
  // R1
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !in_field |=> !rd_req_o);

  // R3
  base_pick_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    field_start_i |=> shd_base == $past(field_sel_i ? base_short_i : base_long_i));

  // R4
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_req_o && $past(rd_req_o)) |-> rd_addr_o == $past(rd_addr_o) + 1'b1);

  // R6
  line_bound_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    lines_done <= {1'b0, shd_geom.hgt_m1} + 1'b1);
endmodule

bind dwin_fetch_addr dwin_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_ns(rst_ns),
  .field_start_i(field_start_i), .field_sel_i(field_sel_i),
  .base_long_i(base_long_i), .base_short_i(base_short_i),
  .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
  .in_field(in_field), .shd_base(shd_base), .shd_geom(shd_geom),
  .lines_done(lines_done)
);

// File: tb/dwin_fetch_addr_tb.sv
`timescale 1ns/100ps
module dwin_fetch_addr_tb;
  localparam int AW = 24;

  typedef struct packed {
    logic          sel;
    logic [AW-1:0] lb;
    logic [AW-1:0] sb;
    logic [9:0]    w;
    logic [9:0]    h;
    logic [9:0]    m;
    logic          stall;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 24'h001000, 24'h001008, 10'd7, 10'd2, 10'd1, 1'b0},
    '{1'b0, 24'h002000, 24'h002004, 10'd3, 10'd1, 10'd5, 1'b1},
    '{1'b1, 24'h002000, 24'h002004, 10'd3, 10'd1, 10'd5, 1'b0},
    '{1'b0, 24'h00FFFF, 24'h000000, 10'd0, 10'd0, 10'd1, 1'b0},
    '{1'b1, 24'h000010, 24'h000030, 10'd5, 10'd3, 10'd3, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          field_start_i = 1'b0, field_sel_i = 1'b0;
  logic          line_start_i = 1'b0, win_active_i = 1'b0;
  logic [AW-1:0] base_long_i = '0, base_short_i = '0;
  logic [29:0]   size_i = '0;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;

  int            n_chk = 0, n_bad = 0;
  logic [AW-1:0] exp_base;
  int            exp_step, exp_ln, exp_wd, nreq;
  string         mon_tag = "R5";

  always #2.5 clk = ~clk;

  dwin_fetch_addr #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .field_start_i(field_start_i), .field_sel_i(field_sel_i),
    .line_start_i(line_start_i), .win_active_i(win_active_i),
    .base_long_i(base_long_i), .base_short_i(base_short_i),
    .size_i(size_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_req_o === 1'b1) begin
      logic [AW-1:0] e;
      e = exp_base + AW'(exp_ln * exp_step) + AW'(exp_wd);
      chk(rd_addr_o == e, mon_tag, int'(rd_addr_o), int'(e));
      exp_wd++;
      nreq++;
    end
  end

  task automatic run_line(input int ln, input int w, input bit stall,
                          input int expn, input string tag);
    exp_ln = ln;
    exp_wd = 0;
    nreq   = 0;
    line_start_i = 1'b1;
    tick();
    line_start_i = 1'b0;
    for (int c = 0; c < w + 4; c++) begin
      win_active_i = !(stall && (c == 1 || c == 2));
      tick();
    end
    win_active_i = 1'b0;
    tick();
    tick();
    chk(nreq == expn, tag, nreq, expn);
  endtask

  task automatic start_field(input bit sel, input logic [AW-1:0] lb,
                             input logic [AW-1:0] sb, input int w, input int h,
                             input int m);
    field_sel_i  = sel;
    base_long_i  = lb;
    base_short_i = sb;
    size_i       = {10'(m), 10'(h), 10'(w)};
    field_start_i = 1'b1;
    tick();
    field_start_i = 1'b0;
    exp_base = sel ? sb : lb;
    exp_step = w + m;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    // R1 reset state
    chk(rd_req_o == 1'b0, "R1", int'(rd_req_o), 0);
    chk(rd_addr_o == '0, "R1", int'(rd_addr_o), 0);
    // R1 no requests before any field start
    run_line(0, 3, 1'b0, 0, "R1");

    // R2 R3 R4 R5: vector table
    for (int v = 0; v < NV; v++) begin
      mon_tag = "R3 R5";
      start_field(VEC[v].sel, VEC[v].lb, VEC[v].sb,
                  int'(VEC[v].w), int'(VEC[v].h), int'(VEC[v].m));
      for (int ln = 0; ln <= int'(VEC[v].h); ln++)
        run_line(ln, int'(VEC[v].w), VEC[v].stall, int'(VEC[v].w) + 1, "R2 R4");
      // R6 no fetch after height+1 lines
      run_line(0, int'(VEC[v].w), 1'b0, 0, "R6");
    end

    // R7 mid-field changes ignored until next field start
    mon_tag = "R7";
    start_field(1'b0, 24'h004000, 24'h004010, 3, 1, 1);
    base_long_i = 24'h008000;
    size_i      = {10'd9, 10'd5, 10'd6};
    run_line(0, 3, 1'b0, 4, "R7");
    base_long_i = 24'h009000;
    run_line(1, 3, 1'b0, 4, "R7");
    run_line(0, 3, 1'b0, 0, "R7");
    start_field(1'b0, 24'h009000, 24'h004010, 6, 5, 9);
    run_line(0, 6, 1'b0, 7, "R7");
    run_line(1, 6, 1'b1, 7, "R7");

    // R5 interlaced short field, line length 4
    mon_tag = "R5";
    start_field(1'b1, 24'h00A000, 24'h00A004, 3, 2, 5);
    for (int ln = 0; ln < 3; ln++) run_line(ln, 3, 1'b0, 4, "R5");

    finish_run();
  end
endmodule